// File: doc/BRIEF.md
# Post-Increment Pointer Transfer Sequencer

This block sequences a single memory transfer addressed through one of two 16-bit pointers (called P and Q here), with the pointer bumped after the access. Byte transfers move one of three 8-bit registers (A, B, C) to or from memory. Word transfers move one pointer through the other as two bytes: the high byte sits at the pointer address and the low byte at the next address. The block drives the memory address, write strobe and write data. It returns loaded values to an external register file. It asks an external pointer adder to add 1 or 2 to the pointer that was used for addressing.

A transfer starts when `start` is high with an opcode in the range 0xC0 to 0xCF while the block is idle. The pointer, store data and mode flag are captured in that accepting cycle. A byte transfer then runs for two cycles and a word transfer for three. `done` marks the last cycle. When `no_inc` is high at acceptance, the same access is made but no increment request is issued.

Top module: `ptr_xfer_seq`

## Requirements
- R1: A transfer is accepted only when `start` is high, `opcode[7:4]` is 0xC and the block is idle. Any other opcode, or a `start` while busy, is ignored, and while idle `mem_we`, `inc_req` and `rf_we` stay low.
- R2: Opcodes 0xC0, 0xC1, 0xC2 store A, B, C to the byte at P. Opcodes 0xC3, 0xC4, 0xC5 store A, B, C to the byte at Q. The write is made in the first cycle after acceptance.
- R3: Opcodes 0xC6, 0xC7, 0xC8 load A, B, C from the byte at P. Opcodes 0xC9, 0xCA, 0xCB load A, B, C from the byte at Q. In the first cycle, `rf_we` is high with `rf_wdata` equal to the memory byte zero-extended, and `rf_dst` is 0 for A, 1 for B, 2 for C, 3 for P and 4 for Q.
- R4: A byte transfer lasts two cycles. The access and a +1 increment request on the addressing pointer occur in the first cycle, and `done` occurs in the second.
- R5: Opcode 0xCC loads Q from the word at P, and 0xCD loads P from the word at Q. The high byte is read at the pointer and the low byte at the pointer plus 1. `rf_we` with {high, low} comes in the third cycle, together with `done`.
- R6: Opcode 0xCE stores P to the word at Q, and 0xCF stores Q to the word at P. The high byte is written in the first cycle at the pointer and the low byte in the second cycle at the pointer plus 1. There is no write in the third cycle.
- R7: A word transfer issues a single +2 increment request on the addressing pointer, in its second cycle only. `inc_sel` is 0 for P and 1 for Q.
- R8: The second byte of a word transfer is addressed at the pointer value captured at acceptance plus 1, whatever the pointer input does afterwards.
- R9: With `no_inc` high at acceptance, no increment request is made. Cycle count and accesses are unchanged.
- R10: `done` is a one-cycle pulse in the final cycle. `busy` is high from the cycle after acceptance through the `done` cycle.
- R11: `mem_we` is high only in the access cycles of a store.
- R12: Store data is captured at acceptance, so later changes of the source register do not alter the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a transfer |
| opcode | input | 8 | Transfer code, 0xC0 to 0xCF |
| no_inc | input | 1 | Suppress the pointer increment for this transfer |
| ptr_p | input | 16 | Current value of pointer P |
| ptr_q | input | 16 | Current value of pointer Q |
| reg_a | input | 8 | Current value of register A |
| reg_b | input | 8 | Current value of register B |
| reg_c | input | 8 | Current value of register C |
| mem_rdata | input | 8 | Memory read data for the present address (same cycle) |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| inc_req | output | 1 | Increment request to the pointer adder |
| inc_sel | output | 1 | Pointer to increment: 0 = P, 1 = Q |
| inc_step | output | 2 | Increment amount, 1 or 2 |
| rf_we | output | 1 | Register file write strobe |
| rf_dst | output | 3 | Register file destination code |
| rf_wdata | output | 16 | Register file write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Final cycle of a transfer |

## Verification
Every result is tied to a cycle counted from the edge that accepts `start`. The first access, byte load write-back and +1 request fall in cycle 1. The second word byte and the +2 request fall in cycle 2. `done` falls in cycle 2 for bytes and cycle 3 for words, and the word load write-back also comes in cycle 3. The bench drives at the falling edge and records every output at each following falling edge until `done`. It then compares the recorded cycle-by-cycle trace against these positions. It also checks the memory and pointer models it keeps once the transfer has settled.

// File: rtl/ptr_xfer_pkg.sv
package ptr_xfer_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_B_ACC = 3'd1,
    ST_B_FIN = 3'd2,
    ST_W_HI  = 3'd3,
    ST_W_LO  = 3'd4,
    ST_W_FIN = 3'd5
  } seq_state_e;

  typedef enum logic [2:0] {
    RD_A = 3'd0,
    RD_B = 3'd1,
    RD_C = 3'd2,
    RD_P = 3'd3,
    RD_Q = 3'd4
  } reg_id_e;

  typedef struct packed {
    logic    valid;
    logic    word;
    logic    store;
    logic    via_q;
    reg_id_e data_reg;
  } xfer_op_t;

  localparam logic [3:0] XFER_GROUP = 4'hC;
  localparam logic [3:0] WORD_FIRST = 4'd12;
  localparam logic [3:0] BYTE_HALF  = 4'd6;

  // Opcode field split: low nibble 0..5 byte stores, 6..11 byte loads,
  // 12..15 word transfers; inside each byte half, 0..2 via P, 3..5 via Q.
  function automatic xfer_op_t decode_op(input logic [7:0] op);
    xfer_op_t   r;
    logic [3:0] idx;
    logic [3:0] sub;
    logic [3:0] reg_n;
    idx     = op[3:0];
    r.valid = (op[7:4] == XFER_GROUP);
    r.word  = (idx >= WORD_FIRST);
    if (r.word) begin
      r.store    = idx[1];
      r.via_q    = (idx == 4'd13) || (idx == 4'd14);
      r.data_reg = r.via_q ? RD_P : RD_Q;
    end else begin
      r.store    = (idx < BYTE_HALF);
      sub        = r.store ? idx : idx - BYTE_HALF;
      r.via_q    = (sub >= 4'd3);
      reg_n      = r.via_q ? sub - 4'd3 : sub;
      r.data_reg = reg_id_e'(reg_n[2:0]);
    end
    return r;
  endfunction

  function automatic logic [1:0] step_for(input logic word);
    return word ? 2'd2 : 2'd1;
  endfunction

endpackage

// File: rtl/ptr_xfer_dec.sv
module ptr_xfer_dec
  import ptr_xfer_pkg::*;
(
  input  logic [7:0] opcode,
  output xfer_op_t   op_info
);

  always_comb op_info = decode_op(opcode);

endmodule

// File: rtl/ptr_xfer_ctl.sv
module ptr_xfer_ctl
  import ptr_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  xfer_op_t   dec_op,
  input  logic       no_inc,
  output logic       accept,
  output logic       busy,
  output logic       done,
  output logic       acc_hi,
  output logic       acc_lo,
  output logic       cur_word,
  output logic       mem_we,
  output logic       inc_req,
  output logic       inc_sel,
  output logic [1:0] inc_step,
  output logic       rf_we,
  output logic [2:0] rf_dst
);

  seq_state_e state, state_nx;
  logic       cur_store;
  logic       cur_via_q;
  logic       cur_noinc;
  reg_id_e    cur_reg;
  logic       fin;

  assign accept = start && dec_op.valid && (state == ST_IDLE);

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (accept) state_nx = dec_op.word ? ST_W_HI : ST_B_ACC;
      ST_B_ACC: state_nx = ST_B_FIN;
      ST_B_FIN: state_nx = ST_IDLE;
      ST_W_HI:  state_nx = ST_W_LO;
      ST_W_LO:  state_nx = ST_W_FIN;
      ST_W_FIN: state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_word  <= 1'b0;
      cur_store <= 1'b0;
      cur_via_q <= 1'b0;
      cur_noinc <= 1'b0;
      cur_reg   <= RD_A;
    end else begin
      state <= state_nx;
      if (accept) begin
        cur_word  <= dec_op.word;
        cur_store <= dec_op.store;
        cur_via_q <= dec_op.via_q;
        cur_noinc <= no_inc;
        cur_reg   <= dec_op.data_reg;
      end
    end
  end

  assign acc_hi   = (state == ST_B_ACC) || (state == ST_W_HI);
  assign acc_lo   = (state == ST_W_LO);
  assign fin      = (state == ST_B_FIN) || (state == ST_W_FIN);
  assign done     = fin;
  assign busy     = (state != ST_IDLE);

  assign mem_we   = cur_store && (acc_hi || acc_lo);
  assign inc_req  = !cur_noinc && (cur_word ? acc_lo : acc_hi);
  assign inc_sel  = cur_via_q;
  assign inc_step = step_for(cur_word);
  assign rf_we    = !cur_store && (cur_word ? fin : acc_hi);
  assign rf_dst   = cur_reg;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BYTE_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_B_FIN) |-> ($past(state) == ST_B_ACC)); // R4
  AST_WORD_INC_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && cur_word) |=> done); // R7
  AST_WE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (cur_store && !done)); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !inc_req && !rf_we)); // R1

endmodule

// File: rtl/ptr_xfer_dp.sv
module ptr_xfer_dp
  import ptr_xfer_pkg::*;
#(
  parameter int DW = 8,
  parameter int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  xfer_op_t      dec_op,
  input  logic [PW-1:0] ptr_p,
  input  logic [PW-1:0] ptr_q,
  input  logic [DW-1:0] reg_a,
  input  logic [DW-1:0] reg_b,
  input  logic [DW-1:0] reg_c,
  input  logic          acc_hi,
  input  logic          acc_lo,
  input  logic          cur_word,
  input  logic [DW-1:0] mem_rdata,
  output logic [PW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [PW-1:0] rf_wdata
);

  localparam int ZW = PW - DW;

  logic [PW-1:0] base_q;
  logic [PW-1:0] src_q;
  logic [PW-1:0] src_sel;
  logic [DW-1:0] hi_q;
  logic [DW-1:0] lo_q;

  function automatic logic [PW-1:0] second_addr(input logic [PW-1:0] b);
    return b + PW'(1);
  endfunction

  function automatic logic [PW-1:0] widen(input logic [DW-1:0] v);
    return {{ZW{1'b0}}, v};
  endfunction

  always_comb begin
    unique case (dec_op.data_reg)
      RD_A:    src_sel = widen(reg_a);
      RD_B:    src_sel = widen(reg_b);
      RD_C:    src_sel = widen(reg_c);
      RD_P:    src_sel = ptr_p;
      RD_Q:    src_sel = ptr_q;
      default: src_sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      src_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      if (accept) begin
        base_q <= dec_op.via_q ? ptr_q : ptr_p;
        src_q  <= src_sel;
      end
      if (acc_hi && cur_word) hi_q <= mem_rdata;
      if (acc_lo)             lo_q <= mem_rdata;
    end
  end

  assign mem_addr  = acc_lo ? second_addr(base_q) : base_q;
  assign mem_wdata = (cur_word && !acc_lo) ? src_q[PW-1:DW] : src_q[DW-1:0];
  assign rf_wdata  = cur_word ? {hi_q, lo_q} : widen(mem_rdata);

  AST_LO_ADDR_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_lo |-> (mem_addr == PW'($past(mem_addr) + PW'(1)))); // R8
  AST_LO_FOLLOWS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    acc_lo |-> $past(acc_hi)); // R5

endmodule

// File: rtl/ptr_xfer_seq.sv
module ptr_xfer_seq
  import ptr_xfer_pkg::*;
#(
  parameter int DW = 8,
  localparam int PW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [7:0]    opcode,
  input  logic          no_inc,
  input  logic [PW-1:0] ptr_p,
  input  logic [PW-1:0] ptr_q,
  input  logic [DW-1:0] reg_a,
  input  logic [DW-1:0] reg_b,
  input  logic [DW-1:0] reg_c,
  input  logic [DW-1:0] mem_rdata,
  output logic [PW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata,
  output logic          inc_req,
  output logic          inc_sel,
  output logic [1:0]    inc_step,
  output logic          rf_we,
  output logic [2:0]    rf_dst,
  output logic [PW-1:0] rf_wdata,
  output logic          busy,
  output logic          done
);

  xfer_op_t dec_op;
  logic     accept;
  logic     acc_hi;
  logic     acc_lo;
  logic     cur_word;

  ptr_xfer_dec u_dec (
    .opcode  (opcode),
    .op_info (dec_op)
  );

  ptr_xfer_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dec_op   (dec_op),
    .no_inc   (no_inc),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .acc_hi   (acc_hi),
    .acc_lo   (acc_lo),
    .cur_word (cur_word),
    .mem_we   (mem_we),
    .inc_req  (inc_req),
    .inc_sel  (inc_sel),
    .inc_step (inc_step),
    .rf_we    (rf_we),
    .rf_dst   (rf_dst)
  );

  ptr_xfer_dp #(.DW(DW), .PW(PW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .dec_op    (dec_op),
    .ptr_p     (ptr_p),
    .ptr_q     (ptr_q),
    .reg_a     (reg_a),
    .reg_b     (reg_b),
    .reg_c     (reg_c),
    .acc_hi    (acc_hi),
    .acc_lo    (acc_lo),
    .cur_word  (cur_word),
    .mem_rdata (mem_rdata),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .rf_wdata  (rf_wdata)
  );

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy); // R10
  AST_STEP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    inc_req |-> ((inc_step == 2'd1) || (inc_step == 2'd2))); // R4

endmodule

// File: tb/ptr_xfer_seq_bench.sv
`timescale 1ns/1ps
module ptr_xfer_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        no_inc = 1'b0;
  logic [15:0] p_r, q_r;
  logic [7:0]  a_r, b_r, c_r;
  logic [7:0]  mem [256];
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr;
  logic        mem_we;
  logic [7:0]  mem_wdata;
  logic        inc_req, inc_sel, rf_we, busy, done;
  logic [1:0]  inc_step;
  logic [2:0]  rf_dst;
  logic [15:0] rf_wdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [15:0] t_addr  [4];
  logic        t_we    [4];
  logic [7:0]  t_wdata [4];
  logic        t_inc   [4];
  logic        t_sel   [4];
  logic [1:0]  t_step  [4];
  logic        t_rfwe  [4];
  logic [2:0]  t_dst   [4];
  logic [15:0] t_rfdat [4];
  logic        t_done  [4];
  int          t_len;

  always #2 clk = ~clk;

  ptr_xfer_seq u_ptr_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .no_inc(no_inc),
    .ptr_p(p_r), .ptr_q(q_r), .reg_a(a_r), .reg_b(b_r), .reg_c(c_r),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .inc_req(inc_req), .inc_sel(inc_sel),
    .inc_step(inc_step), .rf_we(rf_we), .rf_dst(rf_dst), .rf_wdata(rf_wdata),
    .busy(busy), .done(done)
  );

  // memory, pointer adder and register file models around the block
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (inc_req) begin
      if (inc_sel) q_r <= q_r + 16'(inc_step);
      else         p_r <= p_r + 16'(inc_step);
    end
    if (rf_we) begin
      case (rf_dst)
        3'd0: a_r <= rf_wdata[7:0];
        3'd1: b_r <= rf_wdata[7:0];
        3'd2: c_r <= rf_wdata[7:0];
        3'd3: p_r <= rf_wdata;
        3'd4: q_r <= rf_wdata;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    if (cyc > 20000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one transfer, record every window until done
  task automatic run_op(input logic [7:0] op, input logic ni, input int perturb);
    @(negedge clk);
    start = 1'b1; opcode = op; no_inc = ni;
    @(negedge clk);
    start = 1'b0;
    t_len = 0;
    for (int i = 0; i < 4; i++) begin
      t_addr[i] = mem_addr; t_we[i] = mem_we; t_wdata[i] = mem_wdata;
      t_inc[i] = inc_req; t_sel[i] = inc_sel; t_step[i] = inc_step;
      t_rfwe[i] = rf_we; t_dst[i] = rf_dst; t_rfdat[i] = rf_wdata;
      t_done[i] = done;
      if (i == 0 && perturb == 1) a_r = 8'h99;
      if (i == 0 && perturb == 2) q_r = 16'h00F0;
      if (done) begin
        t_len = i + 1;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R10", "busy after reset", busy, 0);
    chk("R10", "done after reset", done, 0);
    chk("R1", "idle mem_we", mem_we, 0);
    chk("R1", "idle inc_req", inc_req, 0);
    chk("R1", "idle rf_we", rf_we, 0);
  endtask

  task automatic t_byte_store;
    p_r = 16'h0010; q_r = 16'h0020; a_r = 8'h11; b_r = 8'h22; c_r = 8'h33;
    run_op(8'hC1, 1'b0, 0);
    chk("R4", "C1 length", t_len, 2);
    chk("R2", "C1 we cycle1", t_we[0], 1);
    chk("R2", "C1 addr", t_addr[0], 16'h0010);
    chk("R2", "C1 wdata", t_wdata[0], 8'h22);
    chk("R4", "C1 inc step", {t_inc[0], t_sel[0], t_step[0]}, {1'b1, 1'b0, 2'd1});
    chk("R11", "C1 no we in done cycle", t_we[1], 0);
    chk("R10", "C1 done cycle 2", t_done[1], 1);
    chk("R2", "C1 memory", mem[8'h10], 8'h22);
    chk("R4", "C1 P bumped", p_r, 16'h0011);
    run_op(8'hC5, 1'b0, 0);
    chk("R2", "C5 addr via Q", t_addr[0], 16'h0020);
    chk("R2", "C5 memory", mem[8'h20], 8'h33);
    chk("R4", "C5 Q bumped", q_r, 16'h0021);
    chk("R4", "C5 inc sel Q", t_sel[0], 1);
    chk("R10", "busy cleared after C5", busy, 0);
  endtask

  task automatic t_byte_load;
    logic [7:0] e;
    p_r = 16'h0030; q_r = 16'h0031;
    e = mem[8'h30];
    run_op(8'hC6, 1'b0, 0);
    chk("R3", "C6 rf_we cycle1", t_rfwe[0], 1);
    chk("R3", "C6 dst A", t_dst[0], 3'd0);
    chk("R3", "C6 data", t_rfdat[0], {8'h00, e});
    chk("R11", "C6 no write", t_we[0], 0);
    chk("R3", "C6 A loaded", a_r, e);
    chk("R4", "C6 P bumped", p_r, 16'h0031);
    e = mem[8'h31];
    run_op(8'hCA, 1'b0, 0);
    chk("R3", "CA dst B", t_dst[0], 3'd1);
    chk("R3", "CA B loaded", b_r, e);
    chk("R4", "CA Q bumped", q_r, 16'h0032);
    chk("R4", "CA length", t_len, 2);
  endtask

  task automatic t_word_load;
    logic [15:0] e;
    p_r = 16'h0040; q_r = 16'h0000;
    e = {mem[8'h40], mem[8'h41]};
    run_op(8'hCC, 1'b0, 0);
    chk("R5", "CC length", t_len, 3);
    chk("R5", "CC hi addr", t_addr[0], 16'h0040);
    chk("R5", "CC lo addr", t_addr[1], 16'h0041);
    chk("R7", "CC no inc in cycle1", t_inc[0], 0);
    chk("R7", "CC +2 in cycle2", {t_inc[1], t_sel[1], t_step[1]}, {1'b1, 1'b0, 2'd2});
    chk("R7", "CC no inc in cycle3", t_inc[2], 0);
    chk("R5", "CC rf_we only cycle3", {t_rfwe[0], t_rfwe[1], t_rfwe[2]}, 3'b001);
    chk("R5", "CC dst Q", t_dst[2], 3'd4);
    chk("R5", "CC Q value", q_r, e);
    chk("R7", "CC P plus 2", p_r, 16'h0042);
    q_r = 16'h0050;
    e = {mem[8'h50], mem[8'h51]};
    run_op(8'hCD, 1'b0, 0);
    chk("R5", "CD P value", p_r, e);
    chk("R7", "CD Q plus 2", q_r, 16'h0052);
    chk("R7", "CD inc sel Q", t_sel[1], 1);
  endtask

  task automatic t_word_store;
    p_r = 16'hBEEF; q_r = 16'h0060;
    run_op(8'hCE, 1'b0, 0);
    chk("R6", "CE we pattern", {t_we[0], t_we[1], t_we[2]}, 3'b110);
    chk("R6", "CE hi byte first", t_wdata[0], 8'hBE);
    chk("R6", "CE mem hi", mem[8'h60], 8'hBE);
    chk("R6", "CE mem lo", mem[8'h61], 8'hEF);
    chk("R7", "CE Q plus 2", q_r, 16'h0062);
    chk("R6", "CE P kept", p_r, 16'hBEEF);
    q_r = 16'h1234; p_r = 16'h0070;
    run_op(8'hCF, 1'b0, 0);
    chk("R6", "CF mem hi", mem[8'h70], 8'h12);
    chk("R6", "CF mem lo", mem[8'h71], 8'h34);
    chk("R7", "CF P plus 2", p_r, 16'h0072);
    chk("R10", "CF done cycle3 only", {t_done[0], t_done[1], t_done[2]}, 3'b001);
  endtask

  task automatic t_noinc;
    p_r = 16'h00A0; a_r = 8'h5C;
    run_op(8'hC0, 1'b1, 0);
    chk("R9", "C0 no_inc length", t_len, 2);
    chk("R9", "C0 no_inc request", t_inc[0] | t_inc[1], 0);
    chk("R9", "C0 no_inc memory", mem[8'hA0], 8'h5C);
    chk("R9", "C0 no_inc P kept", p_r, 16'h00A0);
    q_r = 16'h0000;
    run_op(8'hCC, 1'b1, 0);
    chk("R9", "CC no_inc length", t_len, 3);
    chk("R9", "CC no_inc request", t_inc[0] | t_inc[1] | t_inc[2], 0);
    chk("R9", "CC no_inc P kept", p_r, 16'h00A0);
    chk("R9", "CC no_inc Q", q_r, {mem[8'hA0], mem[8'hA1]});
  endtask

  task automatic t_ignore;
    @(negedge clk);
    start = 1'b1; opcode = 8'h4A;
    @(negedge clk);
    chk("R1", "foreign opcode busy", busy, 0);
    chk("R1", "foreign opcode we", mem_we, 0);
    opcode = 8'hD0;
    @(negedge clk);
    chk("R1", "opcode D0 busy", busy, 0);
    chk("R1", "opcode D0 rf_we", rf_we, 0);
    start = 1'b0;
    // start held while busy: word load then a store request must be dropped
    p_r = 16'h00B0; a_r = 8'h77;
    @(negedge clk);
    start = 1'b1; opcode = 8'hCC;
    @(negedge clk);
    opcode = 8'hC0;
    chk("R1", "busy during hold", busy, 1);
    @(negedge clk);
    chk("R1", "no write while busy held", mem_we, 0);
    @(negedge clk);
    chk("R10", "done in cycle3", done, 1);
    start = 1'b0;
    @(negedge clk);
    chk("R1", "held start not accepted", busy, 0);
    chk("R1", "no store after hold", mem[8'hB2], 8'hB2 ^ 8'h5A);
  endtask

  task automatic t_latch;
    p_r = 16'h0080; a_r = 8'h11;
    run_op(8'hC0, 1'b0, 1);
    chk("R12", "store data from acceptance", mem[8'h80], 8'h11);
    p_r = 16'hCAFE; q_r = 16'h0090;
    run_op(8'hCE, 1'b0, 2);
    chk("R8", "second addr from base", t_addr[1], 16'h0091);
    chk("R8", "lo byte placed at base+1", mem[8'h91], 8'hFE);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    p_r = 16'h0; q_r = 16'h0; a_r = 8'h0; b_r = 8'h0; c_r = 8'h0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_byte_store();
    t_byte_load();
    t_word_load();
    t_word_store();
    t_noinc();
    t_ignore();
    t_latch();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule